// File: doc/BRIEF.md
# Multiplexed four-digit seven-segment driver

The block drives a four-digit, common-anode seven-segment display by lighting one digit at a time. A free-running refresh counter, whose width is a parameter, advances on every clock edge. Its two most significant bits form the digit select. Because these are the top bits of a plain binary counter, each digit gets exactly the same share of time before the scan moves to the next one.

The digit select drives three things. It picks one of the four 4-bit digit values and feeds it to a hex-to-segment decoder. It picks the matching decimal-point bit. It also drives a 2-to-4 decoder that enables the matching anode. All display outputs are active low. With a 50 MHz clock and the default width of 15, each digit stays lit for 2^13 cycles, which is about 163.84 us. The parent instantiates the block once and wires the outputs straight to the display pins.

Top module: `sevseg_scan_drv`

## Requirements
- R1: While rst_ni is low, the refresh counter is held at zero. an_o then reads 4'b1110, and seg_o and dp_o show digit 0. The reset is asynchronous.
- R2: The refresh counter advances by one on every rising clk_i edge once reset is released. It wraps to zero after 2^CNT_W cycles, so the scan pattern repeats with that period.
- R3: The digit select equals the two most significant counter bits. Each digit is therefore enabled for 2^(CNT_W-2) consecutive cycles, in the order 0, 1, 2, 3 and then back to 0.
- R4: an_o is active low and has exactly one bit at 0. When digit k is selected, an_o[k] is 0.
- R5: While digit k is selected, seg_o is the decoded value of digit k_i.
- R6: While digit k is selected, dp_o equals dp_i[k]. The bit is passed through unchanged, so 0 lights the point.
- R7: The decoder covers all 16 values. seg_o[0] is segment A and seg_o[6] is segment G, and a segment is lit when its bit is 0. The codes are: 0:40 1:79 2:24 3:30 4:19 5:12 6:02 7:78 8:00 9:10 A:08 b:03 C:46 d:21 E:06 F:0E (hex).
- R8: The digit and decimal-point inputs reach the outputs through combinational logic only. A change to the selected input shows up within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Refresh clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digit0_i | input | 4 | Value for digit 0 |
| digit1_i | input | 4 | Value for digit 1 |
| digit2_i | input | 4 | Value for digit 2 |
| digit3_i | input | 4 | Value for digit 3 |
| dp_i | input | 4 | Decimal-point value, one bit per digit |
| seg_o | output | 7 | Segments A..G, active low |
| dp_o | output | 1 | Decimal point, active low |
| an_o | output | 4 | Anode enables, active low |

## Verification
The first pattern gives the four digits distinct values, so a swapped or misrouted mux input shows up as the wrong code on a particular anode. The second pattern sets all four digits to the same value and steps that value through all sixteen codes, which exercises every decoder entry on its own and keeps the select path out of the result. A walking decimal-point pattern separates the point mux from the anode decoder. A change to the inputs in the middle of a dwell, together with a reset asserted mid-scan, tells the combinational path and the asynchronous clear apart from anything that would wait for a clock edge.

// File: rtl/sevseg_pkg.sv
package sevseg_pkg;
  localparam int unsigned NUM_DIG = 4;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned VAL_W   = 4;
  localparam int unsigned SEG_W   = 7;

  typedef logic [SEL_W-1:0] dig_sel_t;
  typedef logic [VAL_W-1:0] hex_t;
  typedef logic [SEG_W-1:0] seg_t;

  // active-low segment code, bit0 = A .. bit6 = G
  function automatic seg_t hex_to_seg(input hex_t v);
    seg_t s;
    case (v)
      4'h0: s = 7'b1000000;
      4'h1: s = 7'b1111001;
      4'h2: s = 7'b0100100;
      4'h3: s = 7'b0110000;
      4'h4: s = 7'b0011001;
      4'h5: s = 7'b0010010;
      4'h6: s = 7'b0000010;
      4'h7: s = 7'b1111000;
      4'h8: s = 7'b0000000;
      4'h9: s = 7'b0010000;
      4'ha: s = 7'b0001000;
      4'hb: s = 7'b0000011;
      4'hc: s = 7'b1000110;
      4'hd: s = 7'b0100001;
      4'he: s = 7'b0000110;
      default: s = 7'b0001110;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sevseg_refresh_cnt.sv
module sevseg_refresh_cnt
  import sevseg_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  output dig_sel_t sel_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign sel_o = cnt_q[CNT_W-1 -: SEL_W];
endmodule

// File: rtl/sevseg_digit_mux.sv
module sevseg_digit_mux
  import sevseg_pkg::*;
#(
  parameter int unsigned W = 4,
  parameter int unsigned N = NUM_DIG
) (
  input  dig_sel_t            sel_i,
  input  logic [N-1:0][W-1:0] in_i,
  output logic [W-1:0]        out_o
);
  always_comb begin
    out_o = '0;
    for (int unsigned k = 0; k < N; k++) begin
      if (sel_i == dig_sel_t'(k)) out_o = in_i[k];
    end
  end
endmodule

// File: rtl/sevseg_anode_dec.sv
module sevseg_anode_dec
  import sevseg_pkg::*;
#(
  parameter int unsigned N = NUM_DIG
) (
  input  dig_sel_t     sel_i,
  output logic [N-1:0] an_o
);
  for (genvar k = 0; k < N; k++) begin : g_an
    assign an_o[k] = (sel_i != dig_sel_t'(k));
  end
endmodule

// File: rtl/sevseg_seg_dec.sv
module sevseg_seg_dec
  import sevseg_pkg::*;
(
  input  hex_t val_i,
  output seg_t seg_o
);
  assign seg_o = hex_to_seg(val_i);
endmodule

// File: rtl/sevseg_scan_drv.sv
module sevseg_scan_drv
  import sevseg_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] digit0_i,
  input  logic [3:0] digit1_i,
  input  logic [3:0] digit2_i,
  input  logic [3:0] digit3_i,
  input  logic [3:0] dp_i,
  output logic [6:0] seg_o,
  output logic       dp_o,
  output logic [3:0] an_o
);
  dig_sel_t                     sel;
  hex_t                         val_sel;
  logic [NUM_DIG-1:0][VAL_W-1:0] digits;
  logic [NUM_DIG-1:0][0:0]      dps;
  logic [0:0]                   dp_sel;

  assign digits = {digit3_i, digit2_i, digit1_i, digit0_i};
  assign dps    = dp_i;
  assign dp_o   = dp_sel[0];

  sevseg_refresh_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_o (sel)
  );

  sevseg_digit_mux #(.W(VAL_W)) u_val_mux (
    .sel_i(sel),
    .in_i (digits),
    .out_o(val_sel)
  );

  sevseg_digit_mux #(.W(1)) u_dp_mux (
    .sel_i(sel),
    .in_i (dps),
    .out_o(dp_sel)
  );

  sevseg_seg_dec u_seg (
    .val_i(val_sel),
    .seg_o(seg_o)
  );

  sevseg_anode_dec u_an (
    .sel_i(sel),
    .an_o (an_o)
  );
endmodule

// File: rtl/sevseg_scan_chk.sv
module sevseg_scan_chk #(
  parameter int unsigned CNT_W = 15
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] dp_i,
  input logic [3:0] digit0_i,
  input logic [3:0] digit1_i,
  input logic [3:0] digit2_i,
  input logic [3:0] digit3_i,
  input logic [6:0] seg_o,
  input logic       dp_o,
  input logic [3:0] an_o
);
  localparam logic [CNT_W-1:0] DWELL = CNT_W'(1) << (CNT_W-2);

  logic [3:0]       prev_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 4'b1110;
      run_q  <= '0;
    end else begin
      prev_q <= an_o;
      run_q  <= (an_o != prev_q) ? '0 : run_q + 1'b1;
    end
  end

  a_r4_one_anode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~an_o) == 1);

  a_r3_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(an_o) |-> an_o == {$past(an_o[2:0]), $past(an_o[3])});

  a_r3_dwell_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= DWELL);

  a_r3_dwell_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_o != prev_q) |-> run_q >= DWELL - 1'b1);

  a_r6_dp_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_o == |(dp_i & ~an_o));

  a_r8_seg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(an_o) && $stable({digit3_i, digit2_i, digit1_i, digit0_i})) |-> $stable(seg_o));

  a_r7_some_lit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_o != 7'h7f);
endmodule

bind sevseg_scan_drv sevseg_scan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .dp_i    (dp_i),
  .digit0_i(digit0_i),
  .digit1_i(digit1_i),
  .digit2_i(digit2_i),
  .digit3_i(digit3_i),
  .seg_o   (seg_o),
  .dp_o    (dp_o),
  .an_o    (an_o)
);

// File: tb/sim_sevseg_scan_drv.sv
`timescale 1ns/1ps
module sim_sevseg_scan_drv;
  localparam int W = 4;
  localparam int PERIOD = 1 << W;
  localparam int DW = 1 << (W - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] d0 = 4'h1, d1 = 4'h2, d2 = 4'h3, d3 = 4'h4;
  logic [3:0] dp = 4'b1111;
  logic [6:0] seg;
  logic dpo;
  logic [3:0] an;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sevseg_scan_drv #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .digit0_i(d0), .digit1_i(d1), .digit2_i(d2), .digit3_i(d3),
    .dp_i(dp), .seg_o(seg), .dp_o(dpo), .an_o(an)
  );

  // lit-high table, inverted for the active-low output
  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [6:0] h;
    case (v)
      0: h = 7'h3f;  1: h = 7'h06;  2: h = 7'h5b;  3: h = 7'h4f;
      4: h = 7'h66;  5: h = 7'h6d;  6: h = 7'h7d;  7: h = 7'h07;
      8: h = 7'h7f;  9: h = 7'h6f;  10: h = 7'h77; 11: h = 7'h7c;
      12: h = 7'h39; 13: h = 7'h5e; 14: h = 7'h79; default: h = 7'h71;
    endcase
    return ~h;
  endfunction

  function automatic logic [3:0] pick(input int k);
    case (k)
      0: return d0;
      1: return d1;
      2: return d2;
      default: return d3;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_cnt <= 0;
    else        m_cnt <= (m_cnt + 1) % PERIOD;
  end

  // reference compare on every cycle
  always @(negedge clk) begin
    if (cmp_en) begin
      int k;
      k = (m_cnt / DW) % 4;
      check("R4 anode", int'(an), int'(~(4'b1 << k) & 4'hf));
      check("R5 segments", int'(seg), int'(exp_seg(pick(k))));
      check("R6 decimal point", int'(dpo), int'(dp[k]));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] first_an;
    // R1: reset state
    step(3);
    @(negedge clk);
    check("R1 reset anode", int'(an), 'he);
    check("R1 reset seg", int'(seg), int'(exp_seg(4'h1)));
    check("R1 reset dp", int'(dpo), 1);
    step(1);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R3: dwell and order, distinct digits
    step(2 * PERIOD);

    // R2: wrap returns to the same phase
    @(negedge clk);
    first_an = an;
    step(PERIOD);
    @(negedge clk);
    check("R2 wrap period", int'(an), int'(first_an));

    // R6: walking decimal point
    for (int i = 0; i < 4; i++) begin
      dp = ~(4'b1 << i);
      step(PERIOD);
    end

    // R7: every code on all digits
    for (int v = 0; v < 16; v++) begin
      d0 = 4'(v); d1 = 4'(v); d2 = 4'(v); d3 = 4'(v);
      @(negedge clk);
      check("R7 decode", int'(seg), int'(exp_seg(4'(v))));
      step(1);
    end

    // R8: mid-dwell change visible before next edge
    d0 = 4'h5; d1 = 4'ha; d2 = 4'hc; d3 = 4'he;
    for (int i = 0; i < 8; i++) begin
      d0 = d0 + 4'h3; d1 = d1 + 4'h5; d2 = d2 + 4'h7; d3 = d3 + 4'h9;
      dp = dp ^ 4'b0110;
      @(negedge clk);
      check("R8 same-cycle", int'(seg), int'(exp_seg(pick((m_cnt / DW) % 4))));
      step(3);
    end

    // R1: asynchronous reset mid-scan
    step(DW + 1);
    cmp_en = 1'b0;
    rst_n = 1'b0;
    #0.5;
    check("R1 async clear", int'(an), 'he);
    step(2);
    @(negedge clk);
    check("R1 held in reset", int'(an), 'he);
    step(1);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    step(PERIOD + 3);
    cmp_en = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule